// File: doc/BRIEF.md
# Sequential Shift-Add Multiplier

This block multiplies two unsigned 32-bit operands over many clock cycles and returns the full 64-bit product. It uses one 32-bit adder and a single 64-bit accumulator register. When an operation starts, the multiplier operand is placed in the low half of the accumulator and the upper half is cleared. Each clock performs one step. A step looks at bit 0 of the accumulator; if it is set, the step adds the multiplicand into the upper half. The step then shifts the whole register, together with the adder carry, one place to the right. Because the multiplier bits are consumed from the bottom, the product fills the register as they are used up.

A surrounding pipeline drives the two operands and pulses a start request while the unit is idle. It then waits for a one-cycle completion pulse and reads the product as a high word and a low word. Requests made while the unit is working are dropped. The product stays on the outputs until the next accepted request.

Top module: `mul_top`

## Requirements
- R1: After reset, busy and the completion pulse are low and both product words are zero.
- R2: A start request sampled on a rising edge while busy is low loads the operands, and busy is high in the following cycle.
- R3: The unit stays busy for exactly 32 cycles. The completion pulse goes high on the 33rd rising edge, counting the edge that accepted the request, and stays high for exactly one cycle.
- R4: When the completion pulse is high, prodHi equals bits 63..32 and prodLo equals bits 31..0 of the unsigned product of the two operands that were accepted.
- R5: A start request made while busy is high has no effect: the running result and its completion time are unchanged.
- R6: The adder carry goes into the top bit on every shift. Therefore 0xFFFFFFFF times 0xFFFFFFFF gives 0xFFFFFFFE_00000001.
- R7: While the unit is idle and no request is made, prodHi and prodLo keep their values.
- R8: A zero multiplicand or a zero multiplier gives a zero product.
- R9: Busy and the completion pulse are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| startReq | input | 1 | Request to begin a multiplication |
| mcand | input | 32 | Multiplicand, sampled when a request is accepted |
| mplier | input | 32 | Multiplier, sampled when a request is accepted |
| busy | output | 1 | High while steps are running |
| donePulse | output | 1 | One-cycle pulse when the product is ready |
| prodHi | output | 32 | Upper 32 bits of the product |
| prodLo | output | 32 | Lower 32 bits of the product |

## Verification
If the step counter is wrong, the completion pulse shows up too early or too late, and this is caught at the first completion. If the add or shift path is wrong, or a carry is lost, the product words are wrong at the completion pulse. Operands with long runs of ones and carries into the top bit expose a lost carry within one operation. If a request made during the run leaks into the registers, the result of the run in progress is corrupted.

// File: rtl/mul_pkg.sv
package mul_pkg;
  typedef struct packed {
    logic load;
    logic step;
  } mulCtrlS;
endpackage

// File: rtl/mul_ctrl.sv
module mul_ctrl import mul_pkg::*; #(
  parameter int W = 32
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    startReq,
  output logic    busy,
  output logic    donePulse,
  output mulCtrlS ctrlStb
);
  localparam int CW = (W > 2) ? $clog2(W) : 1;
  localparam logic [CW-1:0] LAST = CW'(W - 1);

  logic [CW-1:0] stepCnt;
  logic          lastStep;

  assign ctrlStb.load = startReq && !busy;
  assign ctrlStb.step = busy;
  assign lastStep     = busy && (stepCnt == LAST);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy      <= 1'b0;
      donePulse <= 1'b0;
      stepCnt   <= '0;
    end else begin
      donePulse <= lastStep;
      if (ctrlStb.load) begin
        busy    <= 1'b1;
        stepCnt <= '0;
      end else if (lastStep) begin
        busy    <= 1'b0;
        stepCnt <= '0;
      end else if (busy) begin
        stepCnt <= stepCnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/mul_datapath.sv
module mul_datapath import mul_pkg::*; #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rstN,
  input  mulCtrlS      ctrlStb,
  input  logic [W-1:0] mcand,
  input  logic [W-1:0] mplier,
  output logic [W-1:0] prodHi,
  output logic [W-1:0] prodLo
);
  localparam int PW = 2 * W;

  logic [PW-1:0] accReg;
  logic [W-1:0]  mcandReg;
  logic [W-1:0]  addend;
  logic [W:0]    partSum;

  assign addend  = accReg[0] ? mcandReg : '0;
  assign partSum = {1'b0, accReg[PW-1:W]} + {1'b0, addend};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      accReg   <= '0;
      mcandReg <= '0;
    end else if (ctrlStb.load) begin
      accReg   <= {{W{1'b0}}, mplier};
      mcandReg <= mcand;
    end else if (ctrlStb.step) begin
      accReg   <= {partSum, accReg[W-1:1]};
    end
  end

  assign prodHi = accReg[PW-1:W];
  assign prodLo = accReg[W-1:0];
endmodule

// File: rtl/mul_top.sv
module mul_top import mul_pkg::*; #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         startReq,
  input  logic [W-1:0] mcand,
  input  logic [W-1:0] mplier,
  output logic         busy,
  output logic         donePulse,
  output logic [W-1:0] prodHi,
  output logic [W-1:0] prodLo
);
  mulCtrlS ctrlStb;

  mul_ctrl #(.W(W)) u_ctrl (
    .clk(clk), .rstN(rstN), .startReq(startReq),
    .busy(busy), .donePulse(donePulse), .ctrlStb(ctrlStb)
  );

  mul_datapath #(.W(W)) u_dp (
    .clk(clk), .rstN(rstN), .ctrlStb(ctrlStb),
    .mcand(mcand), .mplier(mplier), .prodHi(prodHi), .prodLo(prodLo)
  );
endmodule

// File: rtl/mul_checker.sv
module mul_checker #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rstN,
  input logic         startReq,
  input logic [W-1:0] mcand,
  input logic [W-1:0] mplier,
  input logic         busy,
  input logic         donePulse,
  input logic [W-1:0] prodHi,
  input logic [W-1:0] prodLo
);
  localparam int CW = $clog2(W + 1) + 1;

  logic [CW-1:0]  busyCnt;
  logic [2*W-1:0] expProd;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busyCnt <= '0;
      expProd <= '0;
    end else if (startReq && !busy) begin
      busyCnt <= '0;
      expProd <= {{W{1'b0}}, mcand} * {{W{1'b0}}, mplier};
    end else if (busy) begin
      busyCnt <= busyCnt + 1'b1;
    end
  end

  // R9
  busy_done_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(busy && donePulse));

  // R3
  done_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    donePulse |=> !donePulse);

  // R3
  busy_len_chk: assert property (@(posedge clk) disable iff (!rstN)
    donePulse |-> (busyCnt == CW'(W)));

  // R2
  start_accept_chk: assert property (@(posedge clk) disable iff (!rstN)
    (startReq && !busy) |=> busy);

  // R4
  product_chk: assert property (@(posedge clk) disable iff (!rstN)
    donePulse |-> ({prodHi, prodLo} == expProd));

  // R7
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !startReq) |=> ($stable(prodHi) && $stable(prodLo)));
endmodule

bind mul_top mul_checker #(.W(W)) u_chk (
  .clk(clk), .rstN(rstN), .startReq(startReq), .mcand(mcand), .mplier(mplier),
  .busy(busy), .donePulse(donePulse), .prodHi(prodHi), .prodLo(prodLo)
);

// File: tb/tb_mul_top.sv
`timescale 1ns/1ps
module tb_mul_top;
  localparam int W = 32;

  logic         clk = 1'b0;
  logic         rstN;
  logic         startReq;
  logic [W-1:0] mcand, mplier;
  logic         busy, donePulse;
  logic [W-1:0] prodHi, prodLo;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  mul_top #(.W(W)) dut (
    .clk(clk), .rstN(rstN), .startReq(startReq), .mcand(mcand), .mplier(mplier),
    .busy(busy), .donePulse(donePulse), .prodHi(prodHi), .prodLo(prodLo)
  );

  always #2 clk = ~clk;

  function automatic logic [2*W-1:0] refMul(input logic [W-1:0] a, input logic [W-1:0] b);
    logic [2*W-1:0] acc = '0;
    for (int i = 0; i < W; i++)
      if (b[i]) acc = acc + ({{W{1'b0}}, a} << i);
    return acc;
  endfunction

  task automatic check(input string req, input logic [2*W-1:0] act, input logic [2*W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic doOp(input logic [W-1:0] a, input logic [W-1:0] b, input bit disturb);
    int k;
    logic [2*W-1:0] exp, held;
    exp = refMul(a, b);
    @(negedge clk);
    mcand = a; mplier = b; startReq = 1'b1;
    @(negedge clk);
    startReq = 1'b0;
    check("R2 busy after start", {63'b0, busy}, 64'd1);
    k = 1;
    while (!donePulse && k < 100) begin
      if (disturb && k == 10) begin
        startReq = 1'b1; mcand = ~a; mplier = b + 1;   // R5 request while busy
      end else begin
        startReq = 1'b0;
      end
      @(negedge clk);
      k++;
    end
    startReq = 1'b0;
    check(disturb ? "R5 timing with ignored start" : "R3 done latency", 64'(k), 64'd33);
    check("R9 busy low at done", {63'b0, busy}, 64'd0);
    if (a == 0 || b == 0) check("R8 zero product", {prodHi, prodLo}, 64'd0);
    else if (a == '1 && b == '1) check("R6 carry kept", {prodHi, prodLo}, 64'hFFFFFFFE_00000001);
    else check(disturb ? "R5 result with ignored start" : "R4 product", {prodHi, prodLo}, exp);
    held = {prodHi, prodLo};
    @(negedge clk);
    check("R3 done one cycle", {63'b0, donePulse}, 64'd0);
    @(negedge clk);
    check("R7 result held", {prodHi, prodLo}, held);
  endtask

  initial begin
    #(4 * 20000);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] ra, rb;
    void'($urandom(32'h5EED_0042));
    rstN = 1'b0; startReq = 1'b0; mcand = '0; mplier = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 reset busy", {63'b0, busy}, 64'd0);
    check("R1 reset done", {63'b0, donePulse}, 64'd0);
    check("R1 reset product", {prodHi, prodLo}, 64'd0);

    doOp(32'd0, 32'h1234_5678, 1'b0);
    doOp(32'hDEAD_BEEF, 32'd0, 1'b0);
    doOp('1, '1, 1'b0);
    doOp(32'd1, '1, 1'b0);
    doOp(32'h8000_0000, 32'd2, 1'b0);
    doOp('1, 32'h8000_0000, 1'b0);
    doOp(32'd9, 32'd8, 1'b0);
    doOp(32'hCAFE_F00D, 32'h0BAD_1DEA, 1'b1);
    doOp('1, '1, 1'b1);

    for (int i = 0; i < 40; i++) begin
      ra = $urandom();
      rb = $urandom();
      doOp(ra, rb, (i % 5) == 0);
    end

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule